// File: doc/BRIEF.md
# Backplane Event Gatherer

This block is the collecting side of a crate in which several readout modules share one 32-bit parallel bus. Each trigger it accepts is time-stamped and placed in a short queue. Once the programmed delay has passed since that trigger's stamp, the gatherer opens an event record. It then addresses the enabled modules one at a time, lowest index first. Each addressed module answers with a fragment length followed by its data words. The gatherer forwards everything as one framed record toward a downstream data FIFO.

A module that does not answer within a bounded wait is marked in the record's closing word, and the gatherer goes on to the next module. Triggers that arrive while a record is being built wait in the queue, and each keeps its own start time. The gatherer counts the events it has accepted but not yet shipped. It raises `busy` when that count reaches its limit or when the queue is full. Triggers that arrive while `busy` is high are dropped.

Top module: `evt_gather`

## Requirements
- R1: While reset is asserted, `rec_valid`, `busy` and `mod_sel` are all zero.
- R2: For a trigger accepted while the gatherer is idle, the record header appears exactly `cfg_delay` clock edges after the edge that samples the trigger, or 1 edge when `cfg_delay` is 0.
- R3: A record is laid out as follows. The header word has the event number in [31:16] and the enable mask in [15:0]. Each fragment starts with a prefix word holding the module index in [31:28], zero in [27:16] and the fragment length in [15:0]. The closing word has 4'hF in [31:28], zero in [27:16] and the error mask in [15:0].
- R4: Enabled modules are addressed in ascending index order, and disabled modules are never addressed.
- R5: `mod_sel` is one-hot or zero at all times and never has a bit outside `mod_mask`.
- R6: A module that does not assert `bus_ack` within `TMO` cycles of being addressed gets no fragment in the record. Its bit is set in the error mask, and the next module is addressed.
- R7: The data words of a fragment are forwarded unchanged and in order. The fragment ends with the word flagged by `bus_last`.
- R8: Triggers accepted while a record is in progress are kept in arrival order. No record starts earlier than `cfg_delay` edges after its own trigger.
- R9: `busy` is high while the number of outstanding events equals `OUT_MAX` or the trigger queue is full. A trigger seen while `busy` is high creates no record.
- R10: Event numbers in consecutive headers start at 0 and increase by one. A dropped trigger consumes no number.
- R11: `rec_sop` marks only the first word of a record and `rec_eop` only the last. No valid word appears outside a record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig | input | 1 | Trigger pulse, one cycle per trigger |
| cfg_delay | input | DLY_W | Delay from trigger to start of collection, in cycles |
| mod_mask | input | NMOD | Enable bit for each module slot |
| mod_sel | output | NMOD | One-hot address of the module being read |
| bus_ack | input | 1 | Addressed module answers; `bus_len` is valid |
| bus_len | input | LEN_W | Fragment length in words |
| bus_valid | input | 1 | `bus_data` holds a fragment word |
| bus_last | input | 1 | Current word is the last of the fragment |
| bus_data | input | 32 | Shared data bus |
| rec_data | output | 32 | Record word |
| rec_valid | output | 1 | `rec_data` is valid |
| rec_sop | output | 1 | First word of a record |
| rec_eop | output | 1 | Last word of a record |
| busy | output | 1 | New triggers are refused |

## Verification
Isolated triggers under random masks, delays, lengths and answer latencies test the exact start delay and the full record layout. Empty masks and masks with silent modules expose faults in skipping and timeout marking. Bursts of closely spaced triggers separate a correct per-trigger start time from one that is counted from the end of the previous record. A burst longer than the outstanding limit, followed by one more trigger, shows whether dropped triggers stay out of the record stream and out of the numbering.

// File: rtl/evt_pkg.sv
package evt_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_ACK,
    ST_DATA
  } gst_t;

  function automatic logic [WORD_W-1:0] mk_hdr(input logic [15:0] num,
                                               input logic [15:0] msk);
    return {num, msk};
  endfunction

  function automatic logic [WORD_W-1:0] mk_pfx(input logic [3:0] id,
                                               input logic [15:0] len);
    return {id, 12'h000, len};
  endfunction

  function automatic logic [WORD_W-1:0] mk_trl(input logic [15:0] err);
    return {4'hF, 12'h000, err};
  endfunction

endpackage

// File: rtl/trig_fifo.sv
module trig_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, wp_n, rp, rp_n;
  logic [CW-1:0] cnt, cnt_n;

  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign dout  = mem[rp];

  always_comb begin
    wp_n = wp;
    rp_n = rp;
    if (push) wp_n = (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
    if (pop)  rp_n = (rp == PW'(DEPTH - 1)) ? '0 : rp + PW'(1);
    case ({push, pop})
      2'b10:   cnt_n = cnt + CW'(1);
      2'b01:   cnt_n = cnt - CW'(1);
      default: cnt_n = cnt;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      wp  <= wp_n;
      rp  <= rp_n;
      cnt <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

endmodule

// File: rtl/mod_pick.sv
module mod_pick #(
  parameter int NMOD = 6,
  parameter int SW   = 3,
  parameter int IW   = 3
) (
  input  logic [NMOD-1:0] en,
  input  logic [SW-1:0]   from,
  output logic            hit,
  output logic [IW-1:0]   idx
);
  logic [NMOD-1:0] cand;

  for (genvar g = 0; g < NMOD; g++) begin : g_cand
    assign cand[g] = en[g] && (SW'(g) >= from);
  end

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NMOD - 1; i >= 0; i--) begin
      if (cand[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end

endmodule

// File: rtl/occ_track.sv
module occ_track #(
  parameter int OUT_MAX = 4095,
  parameter int OW      = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  input  logic q_full,
  output logic busy
);
  logic [OW-1:0] occ, occ_n;

  always_comb begin
    case ({inc, dec})
      2'b10:   occ_n = occ + OW'(1);
      2'b01:   occ_n = occ - OW'(1);
      default: occ_n = occ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ <= '0;
    else        occ <= occ_n;
  end

  assign busy = (occ == OW'(OUT_MAX)) || q_full;

endmodule

// File: rtl/evt_gather.sv
module evt_gather
  import evt_pkg::*;
#(
  parameter int NMOD    = 6,
  parameter int DLY_W   = 16,
  parameter int TS_W    = 24,
  parameter int QDEPTH  = 4,
  parameter int OUT_MAX = 4095,
  parameter int TMO     = 64,
  parameter int LEN_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic [DLY_W-1:0]  cfg_delay,
  input  logic [NMOD-1:0]   mod_mask,
  output logic [NMOD-1:0]   mod_sel,
  input  logic              bus_ack,
  input  logic [LEN_W-1:0]  bus_len,
  input  logic              bus_valid,
  input  logic              bus_last,
  input  logic [WORD_W-1:0] bus_data,
  output logic [WORD_W-1:0] rec_data,
  output logic              rec_valid,
  output logic              rec_sop,
  output logic              rec_eop,
  output logic              busy
);
  localparam int IW = (NMOD > 1) ? $clog2(NMOD) : 1;
  localparam int SW = $clog2(NMOD + 1);
  localparam int TW = $clog2(TMO + 1);
  localparam int OW = $clog2(OUT_MAX + 1);

  // reset: asserted at once, released after two edges
  logic [1:0] rs;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs <= 2'b00;
    else        rs <= {rs[0], 1'b1};
  end
  assign rst_q = rs[1];

  // free-running time stamp
  logic [TS_W-1:0] ts;
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) ts <= '0;
    else        ts <= ts + TS_W'(1);
  end

  logic            push, pop, q_empty, q_full, fin;
  logic [TS_W-1:0] q_head;
  logic            ready;

  assign push = trig && !busy;

  trig_fifo #(.DEPTH(QDEPTH), .W(TS_W)) u_q (
    .clk(clk), .rst_n(rst_q), .push(push), .pop(pop), .din(ts),
    .dout(q_head), .empty(q_empty), .full(q_full)
  );

  occ_track #(.OUT_MAX(OUT_MAX), .OW(OW)) u_occ (
    .clk(clk), .rst_n(rst_q), .inc(push), .dec(fin),
    .q_full(q_full), .busy(busy)
  );

  assign ready = !q_empty && ((ts - q_head) >= TS_W'(cfg_delay));

  // sequencer state
  gst_t              st, st_n;
  logic [IW-1:0]     cur, cur_n;
  logic [SW-1:0]     from, from_n;
  logic [NMOD-1:0]   msk, msk_n;
  logic [NMOD-1:0]   err, err_n;
  logic [TW-1:0]     tmo, tmo_n;
  logic [15:0]       num, num_n;
  logic [WORD_W-1:0] od_n;
  logic              ov_n, os_n, oe_n;
  logic              hit;
  logic [IW-1:0]     pick;

  mod_pick #(.NMOD(NMOD), .SW(SW), .IW(IW)) u_pick (
    .en(msk), .from(from), .hit(hit), .idx(pick)
  );

  always_comb begin
    st_n   = st;
    cur_n  = cur;
    from_n = from;
    msk_n  = msk;
    err_n  = err;
    tmo_n  = tmo;
    num_n  = num;
    od_n   = rec_data;
    ov_n   = 1'b0;
    os_n   = 1'b0;
    oe_n   = 1'b0;
    pop    = 1'b0;
    fin    = 1'b0;
    case (st)
      ST_IDLE: begin
        if (ready) begin
          pop    = 1'b1;
          msk_n  = mod_mask;
          err_n  = '0;
          from_n = '0;
          od_n   = mk_hdr(num, 16'(mod_mask));
          ov_n   = 1'b1;
          os_n   = 1'b1;
          st_n   = ST_SCAN;
        end
      end
      ST_SCAN: begin
        if (hit) begin
          cur_n = pick;
          tmo_n = '0;
          st_n  = ST_ACK;
        end else begin
          od_n  = mk_trl(16'(err));
          ov_n  = 1'b1;
          oe_n  = 1'b1;
          num_n = num + 16'd1;
          fin   = 1'b1;
          st_n  = ST_IDLE;
        end
      end
      ST_ACK: begin
        if (bus_ack) begin
          od_n = mk_pfx(4'(cur), 16'(bus_len));
          ov_n = 1'b1;
          st_n = ST_DATA;
        end else if (tmo == TW'(TMO - 1)) begin
          err_n[cur] = 1'b1;
          from_n     = SW'(cur) + SW'(1);
          st_n       = ST_SCAN;
        end else begin
          tmo_n = tmo + TW'(1);
        end
      end
      ST_DATA: begin
        if (bus_valid) begin
          od_n = bus_data;
          ov_n = 1'b1;
          if (bus_last) begin
            from_n = SW'(cur) + SW'(1);
            st_n   = ST_SCAN;
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      st        <= ST_IDLE;
      cur       <= '0;
      from      <= '0;
      msk       <= '0;
      err       <= '0;
      tmo       <= '0;
      num       <= '0;
      rec_data  <= '0;
      rec_valid <= 1'b0;
      rec_sop   <= 1'b0;
      rec_eop   <= 1'b0;
    end else begin
      st        <= st_n;
      cur       <= cur_n;
      from      <= from_n;
      msk       <= msk_n;
      err       <= err_n;
      tmo       <= tmo_n;
      num       <= num_n;
      rec_valid <= ov_n;
      rec_sop   <= os_n;
      rec_eop   <= oe_n;
      if (ov_n) rec_data <= od_n;
    end
  end

  assign mod_sel = (st == ST_ACK || st == ST_DATA)
                   ? ({{(NMOD-1){1'b0}}, 1'b1} << cur) : '0;

endmodule

// File: rtl/evt_gather_chk.sv
module evt_gather_chk #(
  parameter int NMOD = 6,
  parameter int TMO  = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NMOD-1:0] mod_sel,
  input logic [NMOD-1:0] mod_mask,
  input logic            bus_ack,
  input logic            rec_valid,
  input logic            rec_sop,
  input logic            rec_eop,
  input logic [15:0]     rec_num
);
  localparam int WW = $clog2(TMO + 2);

  logic          in_rec, seen, acked;
  logic [15:0]   last_num;
  logic [WW-1:0] wcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_rec   <= 1'b0;
      seen     <= 1'b0;
      last_num <= '0;
      wcnt     <= '0;
      acked    <= 1'b0;
    end else begin
      if (rec_valid && rec_sop) begin
        in_rec   <= 1'b1;
        seen     <= 1'b1;
        last_num <= rec_num;
      end
      if (rec_valid && rec_eop) in_rec <= 1'b0;
      if (mod_sel == '0) begin
        wcnt  <= '0;
        acked <= 1'b0;
      end else if (bus_ack) begin
        acked <= 1'b1;
      end else if (!acked) begin
        wcnt <= wcnt + WW'(1);
      end
    end
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mod_sel)); // R5
  AST_SEL_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_sel & ~mod_mask) == '0); // R4
  AST_ACK_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt <= WW'(TMO)); // R6
  AST_FRAME_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !in_rec) |-> rec_sop); // R11
  AST_FRAME_INNER: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && in_rec) |-> !rec_sop); // R11
  AST_EVNUM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_sop && seen) |-> rec_num == last_num + 16'd1); // R10

endmodule

bind evt_gather evt_gather_chk #(.NMOD(NMOD), .TMO(TMO)) u_chk (
  .clk(clk), .rst_n(rst_n), .mod_sel(mod_sel), .mod_mask(mod_mask),
  .bus_ack(bus_ack), .rec_valid(rec_valid), .rec_sop(rec_sop),
  .rec_eop(rec_eop), .rec_num(rec_data[31:16])
);

// File: tb/sim_evt_gather.sv
`timescale 1ns/100ps
module sim_evt_gather;
  localparam int NMOD    = 6;
  localparam int DLY_W   = 16;
  localparam int TMO     = 16;
  localparam int OUT_MAX = 3;
  localparam int QDEPTH  = 4;
  localparam int LEN_W   = 16;

  logic             clk, rst_n, trig, bus_ack, bus_valid, bus_last;
  logic [DLY_W-1:0] cfg_delay;
  logic [NMOD-1:0]  mod_mask, mod_sel;
  logic [LEN_W-1:0] bus_len;
  logic [31:0]      bus_data, rec_data;
  logic             rec_valid, rec_sop, rec_eop, busy;

  evt_gather #(.NMOD(NMOD), .DLY_W(DLY_W), .TS_W(24), .QDEPTH(QDEPTH),
               .OUT_MAX(OUT_MAX), .TMO(TMO), .LEN_W(LEN_W)) u0 (
    .clk(clk), .rst_n(rst_n), .trig(trig), .cfg_delay(cfg_delay),
    .mod_mask(mod_mask), .mod_sel(mod_sel), .bus_ack(bus_ack),
    .bus_len(bus_len), .bus_valid(bus_valid), .bus_last(bus_last),
    .bus_data(bus_data), .rec_data(rec_data), .rec_valid(rec_valid),
    .rec_sop(rec_sop), .rec_eop(rec_eop), .busy(busy)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  int acc = 0, exp_ev = 0, nrec = 0, sel_bad = 0, frame_bad = 0;
  int hdr_cyc = 0;
  int trig_cyc [256];
  bit exact = 1'b0, in_rec = 1'b0;
  logic [NMOD-1:0] tb_dead = '0;
  logic [15:0] cur_ev = '0;
  logic [31:0] got [$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int len_of(input int m, input int e);
    return 1 + ((m * 3 + e) % 6);
  endfunction

  function automatic logic [31:0] word_of(input int m, input int e, input int i);
    return {4'hD, 4'(m), 8'(e), 16'(i)};
  endfunction

  task automatic check_record();
    logic [31:0] exp [$];
    logic [15:0] errm;
    int d, dmin, bad;
    errm = '0;
    exp.push_back({16'(exp_ev), 16'(mod_mask)});
    for (int m = 0; m < NMOD; m++) begin
      if (mod_mask[m]) begin
        if (tb_dead[m]) errm[m] = 1'b1;
        else begin
          exp.push_back({4'(m), 12'h000, 16'(len_of(m, exp_ev))});
          for (int i = 0; i < len_of(m, exp_ev); i++) exp.push_back(word_of(m, exp_ev, i));
        end
      end
    end
    exp.push_back({4'hF, 12'h000, errm});
    chk(got[0] == exp[0], "R10 R3 header word", got[0], exp[0]);
    dmin = (cfg_delay == 0) ? 1 : int'(cfg_delay);
    d = hdr_cyc - trig_cyc[exp_ev % 256];
    chk(d >= dmin, "R8 start not before own delay", 32'(d), 32'(dmin));
    if (exact) chk(d == dmin, "R2 start delay", 32'(d), 32'(dmin));
    chk(got.size() == exp.size(), "R3 R4 R6 record length", 32'(got.size()), 32'(exp.size()));
    bad = -1;
    for (int i = 0; i < exp.size() && i < got.size(); i++)
      if (bad < 0 && got[i] !== exp[i]) bad = i;
    if (bad >= 0) chk(1'b0, "R3 R4 R6 R7 record word", got[bad], exp[bad]);
    else chk(1'b1, "R7 record words", 0, 0);
    exp_ev++;
    nrec++;
  endtask

  // record monitor and framing/select watchers
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (!$onehot0(mod_sel) || ((mod_sel & ~mod_mask) != '0)) sel_bad++;
        if (rec_valid) begin
          if (rec_sop) begin
            if (in_rec) frame_bad++;
            got.delete();
            cur_ev  = rec_data[31:16];
            hdr_cyc = cyc;
            in_rec  = 1'b1;
          end else if (!in_rec) frame_bad++;
          got.push_back(rec_data);
          if (rec_eop) begin
            in_rec = 1'b0;
            check_record();
          end
        end
      end
    end
  end

  // module-side responder on the shared bus
  initial begin
    bus_ack = 1'b0; bus_valid = 1'b0; bus_last = 1'b0;
    bus_data = '0; bus_len = '0;
    forever begin
      @(negedge clk);
      if (mod_sel != '0) begin
        int m, lat, n;
        m = 0;
        for (int i = 0; i < NMOD; i++) if (mod_sel[i]) m = i;
        if (!tb_dead[m]) begin
          lat = $urandom_range(0, 4);
          repeat (lat) @(negedge clk);
          n = len_of(m, int'(cur_ev));
          bus_ack = 1'b1;
          bus_len = LEN_W'(n);
          @(negedge clk);
          bus_ack = 1'b0;
          for (int i = 0; i < n; i++) begin
            bus_valid = 1'b1;
            bus_data  = word_of(m, int'(cur_ev), i);
            bus_last  = (i == n - 1);
            @(negedge clk);
          end
          bus_valid = 1'b0;
          bus_last  = 1'b0;
        end
      end
    end
  end

  task automatic fire();
    @(negedge clk);
    if (!busy) begin
      trig_cyc[acc % 256] = cyc + 1;
      acc++;
    end
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic wait_recs(input int n);
    int t;
    t = 0;
    while (nrec < n && t < 4000) begin
      @(negedge clk);
      t++;
    end
    chk(nrec >= n, "R8 records arrive", 32'(nrec), 32'(n));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", nrec, acc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4321));
    rst_n = 1'b0; trig = 1'b0; cfg_delay = '0; mod_mask = '0;
    repeat (4) @(negedge clk);
    chk(rec_valid == 1'b0, "R1 reset rec_valid", 32'(rec_valid), 0);
    chk(busy == 1'b0, "R1 reset busy", 32'(busy), 0);
    chk(mod_sel == '0, "R1 reset mod_sel", 32'(mod_sel), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R2: isolated triggers, all modules
    exact = 1'b1;
    mod_mask = 6'h3F; cfg_delay = 16'd20;
    fire(); wait_recs(1);
    cfg_delay = 16'd0;
    fire(); wait_recs(2);
    // R6: silent module 2 inside mask 0x2D
    mod_mask = 6'h2D; tb_dead = 6'h04; cfg_delay = 16'd3;
    fire(); wait_recs(3);
    tb_dead = '0;
    // R4: empty mask gives header and closing word only
    mod_mask = '0; cfg_delay = 16'd7;
    fire(); wait_recs(4);

    // R8: overlapping triggers keep their order and their own delays
    exact = 1'b0;
    mod_mask = 6'h3F; cfg_delay = 16'd5;
    fire(); repeat (2) @(negedge clk);
    fire(); fire();
    wait_recs(7);
    chk(busy == 1'b0, "R9 busy clears when drained", 32'(busy), 0);

    // R9: outstanding limit, then one dropped trigger
    mod_mask = '0; cfg_delay = 16'd100;
    fire(); fire(); fire();
    chk(busy == 1'b1, "R9 busy at limit", 32'(busy), 1);
    fire();
    wait_recs(10);
    repeat (200) @(negedge clk);
    chk(nrec == 10, "R9 dropped trigger made no record", 32'(nrec), 10);
    chk(acc == 10, "R9 dropped trigger not accepted", 32'(acc), 10);
    // R10: numbering continues without a gap
    exact = 1'b1; cfg_delay = 16'd2; mod_mask = 6'h11;
    fire(); wait_recs(11);

    // random isolated events
    for (int k = 0; k < 25; k++) begin
      mod_mask  = NMOD'($urandom);
      tb_dead   = ($urandom_range(0, 3) == 0) ? (NMOD'($urandom) & mod_mask) : '0;
      cfg_delay = DLY_W'($urandom_range(0, 40));
      fire();
      wait_recs(12 + k);
      tb_dead = '0;
    end

    repeat (10) @(negedge clk);
    chk(sel_bad == 0, "R5 select one-hot within mask", 32'(sel_bad), 0);
    chk(frame_bad == 0, "R11 record framing", 32'(frame_bad), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule